// File: doc/BRIEF.md
# Adaptive Inter-Frame Gap Regulator

This block sets the idle time a frame transmitter must leave between data frames, and adapts that time in closed loop. Every accepted frame is reported together with a flag saying whether it is a repeat of a slot that had already gone out before. The block counts accepted frames and repeats over fixed windows of 256 frames. When a window closes, it compares the repeat share against a threshold without any divider. A high share widens the gap, because the receiver is falling behind and frames are being resent before their acknowledgements arrive. A share of zero narrows the gap to recover throughput.

The transmitter asks to send through a valid/ready pair. `send_valid_i` with `send_retx_i` offers one frame. The frame is accepted in a cycle where `send_valid_i` and `send_ready_o` are both high. After each acceptance, `send_ready_o` stays low for exactly the gap value that was current at that moment. The transmitter applies back-pressure by holding `send_valid_i` high and waiting, and no frame is taken while ready is low. `delay_o` is the current gap in clock cycles. The transmitter copies it into the header of each data frame, after the set and slot number field. A start command returns adaptation to its initial state.

Top module: `afd_gap_ctrl`

## Requirements
- R1: After reset, `delay_o` equals DLY_INIT (20 by default) and `send_ready_o` is high.
- R2: A frame is accepted when `send_valid_i` and `send_ready_o` are both high at a rising edge. `send_ready_o` then stays low for exactly the `delay_o` value present at that edge, in clock cycles. A valid held high while ready is low is not accepted and does not reload the gap.
- R3: Every 256th accepted frame since reset or start closes a window, and both counters restart from zero. No adaptation happens before the 256th frame.
- R4: When a window closes with repeats × 16 greater than 256, `delay_o` rises by DLY_STEP (12), saturating at DLY_MAX (40). The new value is visible in the cycle after the closing edge.
- R5: When a window closes with zero repeats, `delay_o` falls by DLY_STEP, saturating at DLY_MIN (6).
- R6: When a window closes with a repeat count from 1 up to 16 inclusive, `delay_o` is unchanged.
- R7: A high `start_i` at a rising edge sets `delay_o` to DLY_INIT, clears both counters and ends any running gap. `send_ready_o` is low while `start_i` is high and high in the following cycle.
- R8: `delay_o` changes only at a window close or a start.
- R9: `send_retx_i` is counted only in a cycle where a frame is accepted. Its value in all other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command; restarts adaptation |
| send_valid_i | input | 1 | Transmitter offers a data frame |
| send_retx_i | input | 1 | Offered frame repeats an already sent slot |
| send_ready_o | output | 1 | Gap elapsed; a frame may be accepted |
| delay_o | output | 16 | Current gap in clock cycles, for the frame header |

## Verification
The hardest condition to reach is a window close at an exact ratio boundary. The window must hold 256 acceptances, each separated by a gap of 20 to 40 cycles, and exactly 16 or 17 of them must be flagged as repeats. The bench drives whole windows through a send task that waits for ready, flags the first N frames of the window, and reads `delay_o` right after the closing acceptance. This covers the 16-versus-17 threshold, both saturation limits, and a start issued mid-window that must discard 200 frames already counted.

// File: rtl/afd_pkg.sv
package afd_pkg;

  // Outcome of one observation window
  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_e;

endpackage

// File: rtl/afd_ratio_window.sv
module afd_ratio_window
  import afd_pkg::*;
#(
  parameter int WIN_FRAMES  = 256,
  parameter int RATIO_SHIFT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic fire_i,
  input  logic retx_i,
  output logic close_o,
  output adj_e verdict_o
);

  localparam int CNT_W = $clog2(WIN_FRAMES + 1);
  localparam int CMP_W = CNT_W + RATIO_SHIFT;

  logic [CNT_W-1:0] all_cnt, retx_cnt;
  logic [CNT_W-1:0] all_nx, retx_nx;
  logic [CMP_W-1:0] retx_scaled, all_ext;
  adj_e             judge;

  // Counts including the frame accepted this cycle
  always_comb begin
    all_nx  = all_cnt + CNT_W'(1);
    retx_nx = retx_cnt + CNT_W'(retx_i);
  end

  assign close_o = fire_i && (all_cnt == CNT_W'(WIN_FRAMES - 1));

  // Ratio test by shift and compare: retx * 2^SHIFT > all
  always_comb begin
    retx_scaled = CMP_W'(retx_nx) << RATIO_SHIFT;
    all_ext     = CMP_W'(all_nx);
    if (retx_nx == '0)
      judge = ADJ_DOWN;
    else if (retx_scaled > all_ext)
      judge = ADJ_UP;
    else
      judge = ADJ_HOLD;
  end

  assign verdict_o = close_o ? judge : ADJ_HOLD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_cnt  <= '0;
      retx_cnt <= '0;
    end else if (clear_i || close_o) begin
      all_cnt  <= '0;
      retx_cnt <= '0;
    end else if (fire_i) begin
      all_cnt  <= all_nx;
      retx_cnt <= retx_nx;
    end
  end

  AST_ALL_BELOW_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    all_cnt < CNT_W'(WIN_FRAMES)); // R3
  AST_RETX_LE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    retx_cnt <= all_cnt); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (all_cnt == '0 && retx_cnt == '0)); // R7
  AST_IDLE_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && !clear_i) |=> ($stable(all_cnt) && $stable(retx_cnt))); // R9

endmodule

// File: rtl/afd_delay_reg.sv
module afd_delay_reg
  import afd_pkg::*;
#(
  parameter int DLY_W    = 16,
  parameter int DLY_INIT = 20,
  parameter int DLY_MIN  = 6,
  parameter int DLY_MAX  = 40,
  parameter int DLY_STEP = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             close_i,
  input  adj_e             verdict_i,
  output logic [DLY_W-1:0] delay_o
);

  localparam int EXT_W = DLY_W + 1;

  logic [DLY_W-1:0] dly_q, dly_up, dly_dn, dly_nx;

  generate
    if (DLY_STEP == 0) begin : g_fixed
      // Zero step: the gap never adapts
      assign dly_up = dly_q;
      assign dly_dn = dly_q;
    end else begin : g_adapt
      logic [EXT_W-1:0] up_sum, dn_floor;
      always_comb begin
        up_sum   = {1'b0, dly_q} + EXT_W'(DLY_STEP);
        dn_floor = EXT_W'(DLY_MIN) + EXT_W'(DLY_STEP);
        dly_up   = (up_sum > EXT_W'(DLY_MAX)) ? DLY_W'(DLY_MAX) : up_sum[DLY_W-1:0];
        dly_dn   = ({1'b0, dly_q} < dn_floor) ? DLY_W'(DLY_MIN) : dly_q - DLY_W'(DLY_STEP);
      end
    end
  endgenerate

  always_comb begin
    dly_nx = dly_q;
    if (close_i) begin
      unique case (verdict_i)
        ADJ_UP:   dly_nx = dly_up;
        ADJ_DOWN: dly_nx = dly_dn;
        default:  dly_nx = dly_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dly_q <= DLY_W'(DLY_INIT);
    else if (clear_i) dly_q <= DLY_W'(DLY_INIT);
    else              dly_q <= dly_nx;
  end

  assign delay_o = dly_q;

  AST_DLY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clear_i) && $past(close_i)) |-> (dly_q >= DLY_W'(DLY_MIN) && dly_q <= DLY_W'(DLY_MAX))); // R4
  AST_DLY_ONLY_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !close_i) |=> $stable(dly_q)); // R8
  AST_START_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (dly_q == DLY_W'(DLY_INIT))); // R7
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && close_i && verdict_i == ADJ_HOLD) |=> $stable(dly_q)); // R6

endmodule

// File: rtl/afd_gap_timer.sv
module afd_gap_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  output logic             idle_o
);

  logic [DLY_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap_cnt <= '0;
    else if (clear_i)        gap_cnt <= '0;
    else if (load_i)         gap_cnt <= load_val_i;
    else if (gap_cnt != '0)  gap_cnt <= gap_cnt - DLY_W'(1);
  end

  assign idle_o = (gap_cnt == '0);

  AST_GAP_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i && load_val_i != '0) |=> !idle_o); // R2
  AST_GAP_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clear_i && gap_cnt != '0) |=> (gap_cnt == $past(gap_cnt) - DLY_W'(1))); // R2
  AST_GAP_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |-> idle_o); // R2

endmodule

// File: rtl/afd_gap_ctrl.sv
module afd_gap_ctrl
  import afd_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int DLY_INIT    = 20,
  parameter int DLY_MIN     = 6,
  parameter int DLY_MAX     = 40,
  parameter int DLY_STEP    = 12,
  parameter int WIN_FRAMES  = 256,
  parameter int RATIO_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             send_valid_i,
  input  logic             send_retx_i,
  output logic             send_ready_o,
  output logic [DLY_W-1:0] delay_o
);

  logic gap_idle;
  logic fire;
  logic win_close;
  adj_e win_verdict;

  // Start takes priority: no frame is taken in its cycle
  assign send_ready_o = gap_idle && !start_i;
  assign fire         = send_valid_i && send_ready_o;

  afd_ratio_window #(
    .WIN_FRAMES (WIN_FRAMES),
    .RATIO_SHIFT(RATIO_SHIFT)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_i),
    .fire_i   (fire),
    .retx_i   (send_retx_i),
    .close_o  (win_close),
    .verdict_o(win_verdict)
  );

  afd_delay_reg #(
    .DLY_W   (DLY_W),
    .DLY_INIT(DLY_INIT),
    .DLY_MIN (DLY_MIN),
    .DLY_MAX (DLY_MAX),
    .DLY_STEP(DLY_STEP)
  ) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_i),
    .close_i  (win_close),
    .verdict_i(win_verdict),
    .delay_o  (delay_o)
  );

  // Gap after a frame uses the delay in force when it was accepted
  afd_gap_timer #(
    .DLY_W(DLY_W)
  ) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_i),
    .load_i    (fire),
    .load_val_i(delay_o),
    .idle_o    (gap_idle)
  );

  AST_READY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> send_ready_o); // R7
  AST_NO_READY_IN_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !send_ready_o); // R7
  AST_BUSY_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (send_valid_i && send_ready_o && delay_o != '0) |=> !send_ready_o); // R2

endmodule

// File: tb/afd_gap_ctrl_tb.sv
module afd_gap_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;
  localparam int INIT = 20, MINV = 6, MAXV = 40, STEP = 12, WIN = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        send_valid_i = 1'b0;
  logic        send_retx_i = 1'b0;
  logic        send_ready_o;
  logic [15:0] delay_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  afd_gap_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .send_valid_i(send_valid_i),
    .send_retx_i (send_retx_i),
    .send_ready_o(send_ready_o),
    .delay_o     (delay_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One frame: wait for ready, offer it for one cycle. noise drives retx high outside acceptance.
  task automatic send(input bit retx, input bit noise);
    @(negedge clk);
    while (!send_ready_o) @(negedge clk);
    send_valid_i = 1'b1;
    send_retx_i  = retx;
    @(negedge clk);
    send_valid_i = 1'b0;
    send_retx_i  = noise;
  endtask

  task automatic send_many(input int count, input int n_retx, input bit noise);
    for (int i = 0; i < count; i++) send(i < n_retx, noise);
    send_retx_i = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    start_i = 1'b1;
    #1;
    check("R7 ready low during start", send_ready_o, 0);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    check("R7 ready high after start", send_ready_o, 1);
    check("R7 delay back to init", delay_o, INIT);
  endtask

  task automatic t_reset();
    check("R1 reset delay", delay_o, INIT);
    check("R1 reset ready", send_ready_o, 1);
  endtask

  task automatic t_gap_length();
    int lo;
    do_start();
    send(1'b0, 1'b0);
    lo = 0;
    while (!send_ready_o) begin lo++; @(negedge clk); end
    check("R2 gap length", lo, INIT);
    do_start();
  endtask

  task automatic t_backpressure();
    int lo;
    do_start();
    @(negedge clk);
    send_valid_i = 1'b1;
    @(negedge clk);
    lo = 0;
    while (!send_ready_o) begin lo++; @(negedge clk); end
    check("R2 valid held through gap", lo, INIT);
    @(negedge clk);
    lo = 0;
    while (!send_ready_o) begin lo++; @(negedge clk); end
    check("R2 second gap under back-pressure", lo, INIT);
    send_valid_i = 1'b0;
    do_start();
  endtask

  task automatic t_down();
    do_start();
    send_many(WIN - 1, 0, 1'b0);
    check("R3 no change before 256th frame", delay_o, INIT);
    send(1'b0, 1'b0);
    check("R5 clean window lowers", delay_o, INIT - STEP);
    send_many(WIN, 0, 1'b0);
    check("R5 floor at minimum", delay_o, MINV);
    send_many(WIN, 0, 1'b0);
    check("R5 stays at minimum", delay_o, MINV);
  endtask

  task automatic t_up();
    do_start();
    send_many(WIN, 17, 1'b0);
    check("R4 17 repeats raise", delay_o, INIT + STEP);
    send_many(WIN, 16, 1'b0);
    check("R6 exactly 16 repeats hold", delay_o, INIT + STEP);
    send_many(WIN, 100, 1'b0);
    check("R4 ceiling at maximum", delay_o, MAXV);
    send_many(WIN, WIN, 1'b0);
    check("R4 stays at maximum", delay_o, MAXV);
  endtask

  task automatic t_small_ratio();
    do_start();
    send_many(WIN, 1, 1'b0);
    check("R6 single repeat holds", delay_o, INIT);
    send_many(WIN - 10, 0, 1'b0);
    check("R8 delay steady mid-window", delay_o, INIT);
  endtask

  task automatic t_start_mid();
    do_start();
    send_many(200, 200, 1'b0);
    check("R8 no change after 200 frames", delay_o, INIT);
    do_start();
    send_many(WIN - 1, 0, 1'b0);
    check("R7 counters cleared by start", delay_o, INIT);
    send(1'b0, 1'b0);
    check("R7 fresh window lowers", delay_o, INIT - STEP);
  endtask

  task automatic t_start_ends_gap();
    do_start();
    send(1'b0, 1'b0);
    check("R2 ready low after send", send_ready_o, 0);
    do_start();
  endtask

  task automatic t_retx_noise();
    do_start();
    send_many(WIN, 0, 1'b1);
    check("R9 retx outside acceptance ignored", delay_o, INIT - STEP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 ready after reset release", send_ready_o, 1);
    t_gap_length();
    t_backpressure();
    t_start_ends_gap();
    t_down();
    t_up();
    t_small_ratio();
    t_start_mid();
    t_retx_noise();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule